// File: doc/BRIEF.md
# Dual-Rail Ripple Adder with Completion Detection

This block adds two WIDTH-bit operands and a carry-in. Each carry is held as a pair of rails. One rail says the carry is one. The other says the carry is zero. While both rails of a position are low, that carry is still unknown. The block raises `done` as soon as every position has a known carry. Its latency therefore depends on the operands and is not fixed at the worst case.

Carry resolution is modelled synchronously. On the start edge, every bit whose operand bits are equal resolves its outgoing carry at once: both ones give a carry of one, both zeros give a carry of zero. The carry-in resolves position zero on the same edge. On each later edge, every still-unknown position takes the rails of the position below it. A run of r consecutive propagating bits (x XOR y = 1) therefore needs r extra edges. The total latency is the longest such run plus one.

A client pulses `start` with the operands and waits for `done`. It then reads the sum, the carry-out and the two's-complement overflow flag. A new `start` may be issued at any time and abandons the addition in flight.

Top module: `cdra_adder`

## Requirements
- R1: On the start edge, each position i+1 whose operand bits x[i] and y[i] are both 1 gets carry one, and each whose bits are both 0 gets carry zero. Both are resolved, whatever the lower carry.
- R2: On the start edge, carry position 0 takes the value of `cin` on its one-rail and the complement on its zero-rail.
- R3: No carry position ever has both rails high. "One-rail only" means carry 1, "zero-rail only" means carry 0, and "neither" means unresolved.
- R4: After the start edge, an unresolved position i+1 with x[i] XOR y[i] = 1 copies the rails of position i one edge later. A resolved position keeps its rails until the next start.
- R5: `done` is low out of reset. It is high exactly when a start has been taken and no carry position is unresolved.
- R6: `done` is first seen high after L+1 rising edges, counting the start edge, where L is the longest run of consecutive bits with x[i] XOR y[i] = 1.
- R7: While `done` is high, `sum` equals (x + y + cin) mod 2^WIDTH and `cout` equals the carry out of the top bit. The operand and carry-in values come from the start edge. Operand inputs are ignored while `start` is low.
- R8: While `done` is high, `ovf` is 1 exactly when the signed (two's-complement) sum is outside the range of a WIDTH-bit signed number.
- R9: While `done` is low, `sum`, `cout` and `ovf` are all zero.
- R10: Once high, `done` stays high until the next start. A start while unresolved restarts the addition with the new operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that captures the operands and carry-in |
| x_in | input | WIDTH | First operand |
| y_in | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Sum, valid while done is high, zero otherwise |
| cout | output | 1 | Carry out of the top bit, valid while done |
| ovf | output | 1 | Two's-complement overflow, valid while done |
| done | output | 1 | All carry positions resolved |

## Verification
The bench builds the adder with WIDTH = 8. At that width, every run length from zero to the full eight-bit propagate chain (including the chain that starts at the carry-in) fits into a few handfuls of vectors. Both overflow directions are also reached with small operands. At that size, a behavioural model compares `done` and the result outputs on every clock. The model derives latency and results only from integer addition and a run count. Restarts in mid-resolution and operand changes between starts are included.

// File: rtl/cdra_pkg.sv
package cdra_pkg;
  typedef struct packed {
    logic one;
    logic zero;
  } rail_t;

  function automatic logic rail_known(rail_t r);
    return r.one | r.zero;
  endfunction
endpackage

// File: rtl/cdra_gkp.sv
module cdra_gkp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] kill,
  output logic [WIDTH-1:0] prop
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = opa[i] & opb[i];
    assign kill[i] = ~opa[i] & ~opb[i];
    assign prop[i] = opa[i] ^ opb[i];
  end
endmodule

// File: rtl/cdra_rails.sv
module cdra_rails
  import cdra_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cin,
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] kill,
  input  logic [WIDTH-1:0] prop,
  output rail_t [WIDTH:0]  rails
);
  rail_t [WIDTH:0] rails_q, rails_d;

  always_comb begin
    rails_d = rails_q;
    if (start) begin
      rails_d[0] = '{one: cin, zero: ~cin};
      for (int i = 0; i < WIDTH; i++) begin
        rails_d[i+1] = '{one: gen[i], zero: kill[i]};
      end
    end else begin
      for (int i = 0; i < WIDTH; i++) begin
        if (prop[i] && !rail_known(rails_q[i+1])) begin
          rails_d[i+1] = rails_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rails_q <= '0;
    end else begin
      rails_q <= rails_d;
    end
  end

  assign rails = rails_q;

  assert_cin_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rails_q[0].one == $past(cin)) && (rails_q[0].zero == !$past(cin)));

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    assert_gen_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && gen[i]) |=> (rails_q[i+1].one && !rails_q[i+1].zero));
    assert_kill_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && kill[i]) |=> (rails_q[i+1].zero && !rails_q[i+1].one));
    assert_copy_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && prop[i] && !rail_known(rails_q[i+1])) |=> (rails_q[i+1] == $past(rails_q[i])));
  end

  for (genvar j = 0; j <= WIDTH; j++) begin : g_pos
    assert_rails_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rails_q[j].one && rails_q[j].zero));
    assert_resolved_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && rail_known(rails_q[j])) |=> $stable(rails_q[j]));
  end
endmodule

// File: rtl/cdra_done.sv
module cdra_done
  import cdra_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  rail_t [WIDTH:0] rails,
  output logic            done
);
  logic [WIDTH:0] known;
  logic           armed_q, armed_d;

  for (genvar j = 0; j <= WIDTH; j++) begin : g_known
    assign known[j] = rail_known(rails[j]);
  end

  always_comb begin
    armed_d = armed_q | start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign done = armed_q & (&known);

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  assert_done_needs_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(known) == WIDTH + 1));
endmodule

// File: rtl/cdra_adder.sv
module cdra_adder
  import cdra_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf,
  output logic             done
);
  localparam int MSB = WIDTH - 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [WIDTH-1:0] x_q, y_q, x_d, y_d;
  logic [WIDTH-1:0] opa, opb;
  logic [WIDTH-1:0] gen, kill, prop;
  logic [WIDTH-1:0] carry_in_bit;
  rail_t [WIDTH:0]  rails;
  logic             done_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (start) begin
      x_d = x_in;
      y_d = y_in;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign opa = start ? x_in : x_q;
  assign opb = start ? y_in : y_q;

  cdra_gkp #(.WIDTH(WIDTH)) u_gkp (
    .opa (opa), .opb (opb), .gen (gen), .kill (kill), .prop (prop)
  );

  cdra_rails #(.WIDTH(WIDTH)) u_rails (
    .clk (clk), .rst_n (rst_int_n), .start (start), .cin (cin),
    .gen (gen), .kill (kill), .prop (prop), .rails (rails)
  );

  cdra_done #(.WIDTH(WIDTH)) u_done (
    .clk (clk), .rst_n (rst_int_n), .start (start), .rails (rails), .done (done_w)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign carry_in_bit[i] = rails[i].one;
  end

  assign done = done_w;
  assign sum  = done_w ? (x_q ^ y_q ^ carry_in_bit) : '0;
  assign cout = done_w & rails[WIDTH].one;
  assign ovf  = done_w & (rails[WIDTH].one ^ rails[MSB].one);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (ovf == ((x_q[MSB] == y_q[MSB]) && (sum[MSB] != x_q[MSB]))));
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done |-> (sum == '0 && !cout && !ovf));
endmodule

// File: tb/sim_cdra_adder.sv
module sim_cdra_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x_in = '0, y_in = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout, ovf, done;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  longint   exp_sum;
  logic     exp_cout, exp_ovf;
  int       exp_lat;
  int       n_since;

  always #5 clk = ~clk;

  cdra_adder #(.WIDTH(W)) u0 (
    .clk (clk), .rst_n (rst_n), .start (start), .x_in (x_in), .y_in (y_in),
    .cin (cin), .sum (sum), .cout (cout), .ovf (ovf), .done (done)
  );

  function automatic int longest_run(logic [W-1:0] a, logic [W-1:0] b);
    int best = 0;
    int cur = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i] ^ b[i]) begin
        cur++;
        if (cur > best) best = cur;
      end else begin
        cur = 0;
      end
    end
    return best;
  endfunction

  task automatic compare(string req, longint got, longint expv);
    n_vec++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d after start)", req, got, expv, n_since);
    end
  endtask

  task automatic check_now();
    logic e_done;
    e_done = (n_since >= exp_lat + 1);
    compare("R6 done timing", done, e_done);
    if (e_done) begin
      compare("R7 sum", sum, exp_sum);
      compare("R7 cout", cout, exp_cout);
      compare("R8 ovf", ovf, exp_ovf);
    end else begin
      compare("R9 idle outputs", {sum, cout, ovf}, 0);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c, int watch);
    longint sa, sb, tot, ful;
    @(negedge clk);
    x_in = a; y_in = b; cin = c; start = 1'b1;
    ful = longint'(a) + longint'(b) + longint'(c);
    exp_sum = ful % (longint'(1) << W);
    exp_cout = ful >= (longint'(1) << W);
    sa = a[W-1] ? longint'(a) - (longint'(1) << W) : longint'(a);
    sb = b[W-1] ? longint'(b) - (longint'(1) << W) : longint'(b);
    tot = sa + sb + longint'(c);
    exp_ovf = (tot > (longint'(1) << (W-1)) - 1) || (tot < -(longint'(1) << (W-1)));
    exp_lat = longest_run(a, b);
    @(negedge clk);
    start = 1'b0;
    x_in = ~a; y_in = a ^ b; cin = ~c;  // R7: operand inputs ignored without start
    n_since = 1;
    check_now();
    for (int k = 1; k < watch; k++) begin
      @(negedge clk);
      n_since++;
      check_now();
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R5 done after reset", done, 0);
    compare("R9 sum after reset", sum, 0);

    apply(8'h00, 8'h00, 1'b0, 3);   // R1 all kill, L=0
    apply(8'hFF, 8'hFF, 1'b1, 3);   // R1 R2 all generate
    apply(8'hFF, 8'h00, 1'b1, 11);  // R4 full chain from carry-in, L=8
    apply(8'hFF, 8'h01, 1'b0, 10);  // R6 run of 7 above a generate
    apply(8'h55, 8'hAA, 1'b0, 11);  // R2 carry-in zero down full chain
    apply(8'h7F, 8'h01, 1'b0, 10);  // R8 positive overflow
    apply(8'h80, 8'h80, 1'b0, 3);   // R8 negative overflow
    apply(8'h0F, 8'hF0, 1'b1, 4);   // R10 restart in flight
    apply(8'h3C, 8'h03, 1'b0, 8);   // R10 new operands after restart
    apply(8'h12, 8'h34, 1'b1, 12);  // R10 done holds
    lf = 8'hA7;
    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] a, b;
      a = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      b = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      apply(a, b, lf[0], (t % 3 == 0) ? 2 : 10);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule